// File: doc/BRIEF.md
# Four-Digit Combination Lock Controller

This block guards an action behind a secret code of four 4-bit digits. The user sets a digit on a 4-bit input and presses an enter button to commit it. After the fourth commit the block reports a pass or a fail. It never reports anything per digit, so the outputs cannot show which digit was wrong. A digit-position output shows how many digits of the current sequence have been taken.

The block counts wrong sequences in a row. When that count reaches three, it locks out and ignores all further entry until reset. A correct sequence clears the count. Right after a correct sequence, the user may raise a program request. The next four committed digits then become the new code, and the block goes back to normal entry. The code after reset is set by a parameter.

Top module: `combo_lock`

## Requirements
- R1: While reset is low at a clock edge, ok_o, bad_o and lockout_o go to 0 and pos_o goes to 0. The stored code goes to DEFAULT_CODE. The digit compared at position i is DEFAULT_CODE[4*i+3:4*i], so the digit in bits [3:0] is entered first.
- R2: A digit is taken only on a rising edge of enter_i, seen at a clock edge. If enter_i stays high for many cycles, exactly one digit is taken.
- R3: pos_o counts the digits taken in the current sequence, from 0 to 3. It advances by one on each digit taken, and returns to 0 when the fourth digit is taken.
- R4: When all four digits of a sequence equal the stored code, in order, ok_o is 1 and bad_o is 0 from the cycle after the fourth digit is taken.
- R5: When any digit of a sequence differs from the stored code, bad_o is 1 and ok_o is 0 from the cycle after the fourth digit. While pos_o is nonzero, both ok_o and bad_o are 0. ok_o and bad_o are never both 1.
- R6: ok_o and bad_o keep their value until the first digit of the next sequence is taken. That digit clears both.
- R7: After three wrong sequences in a row, lockout_o and bad_o are 1 and stay 1 until reset. In lockout, digits and program requests have no effect: pos_o stays 0 and ok_o stays 0.
- R8: A correct sequence resets the count of wrong sequences. Two wrong sequences, then a correct one, then two more wrong ones do not cause lockout.
- R9: prog_req_i is accepted only in a cycle where ok_o is 1 and pos_o is 0. Acceptance clears ok_o. A digit press in the same cycle as an accepted request is not taken. At any other time prog_req_i has no effect.
- R10: After a request is accepted, the next four digits taken replace the stored code, in entry order, and the block returns to normal entry. After that the old code fails and the new code passes.
- R11: While new digits are being programmed, ok_o and bad_o stay 0. pos_o still counts the digits taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| digit_i | input | 4 | Digit value presented for entry |
| enter_i | input | 1 | Enter button level (already debounced) |
| prog_req_i | input | 1 | Request to program a new code |
| ok_o | output | 1 | Last sequence matched the code |
| bad_o | output | 1 | Last sequence did not match |
| lockout_o | output | 1 | Entry locked after repeated failures |
| pos_o | output | 2 | Digits taken in the current sequence |

## Verification
The hardest states to reach from the ports depend on history. Lockout needs three failed sequences with no success between them. Programming needs a success followed by a request before any new digit is entered. Directed sequences drive each of these paths on purpose, including the case where a press and an accepted request arrive in the same cycle. Random sequences then mix correct codes, codes with one digit wrong, random codes, requests and resets. A bench model tracks the stored code through every reprogramming.

// File: rtl/combo_lock_pkg.sv
// Shared types for the combination lock.
package combo_lock_pkg;

    // Top-level control states.
    typedef enum logic [1:0] {
        ST_ENTRY   = 2'd0,
        ST_PROG    = 2'd1,
        ST_LOCKOUT = 2'd2
    } lock_state_e;

endpackage

// File: rtl/combo_lock_edge.sv
// Rising-edge detector for a debounced button level.
// Assumes level_i is already synchronous to clk_i.
// rise_o is combinational and high in the one cycle where the level
// is first seen high.
module combo_lock_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    output logic rise_o
);
    logic level_q;

    // Keep the previous level of the button.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) level_q <= 1'b0;
        else         level_q <= level_i;
    end

    assign rise_o = level_i && !level_q;
endmodule

// File: rtl/combo_lock_code_store.sv
// Holds the secret code as NUM_DIGITS registers, one per digit.
// Each register loads its part of DEFAULT_CODE on reset.
// A write updates the single digit selected by wr_idx_i.
// Reads are combinational, indexed by the entry position.
module combo_lock_code_store #(
    parameter int DIGIT_W    = 4,
    parameter int NUM_DIGITS = 4,
    parameter int POS_W      = 2,
    parameter logic [DIGIT_W*NUM_DIGITS-1:0] DEFAULT_CODE = '0
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [POS_W-1:0]   wr_idx_i,
    input  logic [DIGIT_W-1:0] wr_data_i,
    input  logic [POS_W-1:0]   rd_idx_i,
    output logic [DIGIT_W-1:0] rd_data_o
);
    localparam int CODE_W = DIGIT_W * NUM_DIGITS;

    logic [CODE_W-1:0] code_flat;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_slot
        logic [DIGIT_W-1:0] slot_q;

        // Load this slot from the default code, or write it during programming.
        always_ff @(posedge clk_i) begin
            if (!rst_ni)
                slot_q <= DEFAULT_CODE[g*DIGIT_W +: DIGIT_W];
            else if (wr_en_i && (wr_idx_i == POS_W'(g)))
                slot_q <= wr_data_i;
        end

        assign code_flat[g*DIGIT_W +: DIGIT_W] = slot_q;
    end

    assign rd_data_o = code_flat[rd_idx_i*DIGIT_W +: DIGIT_W];
endmodule

// File: rtl/combo_lock_fail_ctr.sv
// Counts wrong sequences in a row.
// clr_i takes priority over inc_i. The count saturates at MAX_FAILS.
// last_o means the next failure will be the final one allowed.
module combo_lock_fail_ctr #(
    parameter int MAX_FAILS = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CNT_W = $clog2(MAX_FAILS + 1);

    logic [CNT_W-1:0] cnt_q;

    // Clear on success; count failures up to the limit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= '0;
        else if (inc_i && (cnt_q != CNT_W'(MAX_FAILS)))
            cnt_q <= cnt_q + 1'b1;
    end

    assign last_o = (cnt_q == CNT_W'(MAX_FAILS - 1));
endmodule

// File: rtl/combo_lock.sv
// Combination lock controller.
// Takes NUM_DIGITS digits, one per enter press, and keeps a single
// running match flag. The pass/fail result appears only after the last
// digit. After MAX_FAILS failures in a row it locks until reset.
// A program request right after a pass rewrites the code.
// Assumes: enter_i is debounced and synchronous; NUM_DIGITS >= 2.
module combo_lock
    import combo_lock_pkg::*;
#(
    parameter int DIGIT_W    = 4,
    parameter int NUM_DIGITS = 4,
    parameter int MAX_FAILS  = 3,
    parameter logic [DIGIT_W*NUM_DIGITS-1:0] DEFAULT_CODE = 16'h1234
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [DIGIT_W-1:0]            digit_i,
    input  logic                          enter_i,
    input  logic                          prog_req_i,
    output logic                          ok_o,
    output logic                          bad_o,
    output logic                          lockout_o,
    output logic [$clog2(NUM_DIGITS)-1:0] pos_o
);
    localparam int POS_W = $clog2(NUM_DIGITS);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_DIGITS - 1);

    lock_state_e        state_q;
    logic [POS_W-1:0]   pos_q;
    logic               match_q;
    logic               ok_q;
    logic               bad_q;
    logic               press;
    logic               fail_last;
    logic [DIGIT_W-1:0] ref_digit;
    logic               digit_eq;
    logic               at_last;
    logic               prog_take;
    logic               seq_done;
    logic               seq_pass;

    combo_lock_edge u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (enter_i),
        .rise_o  (press)
    );

    combo_lock_code_store #(
        .DIGIT_W      (DIGIT_W),
        .NUM_DIGITS   (NUM_DIGITS),
        .POS_W        (POS_W),
        .DEFAULT_CODE (DEFAULT_CODE)
    ) u_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   ((state_q == ST_PROG) && press),
        .wr_idx_i  (pos_q),
        .wr_data_i (digit_i),
        .rd_idx_i  (pos_q),
        .rd_data_o (ref_digit)
    );

    assign digit_eq  = (digit_i == ref_digit);
    assign at_last   = (pos_q == LAST_POS);
    assign prog_take = (state_q == ST_ENTRY) && ok_q && (pos_q == '0) && prog_req_i;
    assign seq_done  = (state_q == ST_ENTRY) && press && !prog_take && at_last;
    assign seq_pass  = match_q && digit_eq;

    combo_lock_fail_ctr #(
        .MAX_FAILS (MAX_FAILS)
    ) u_fails (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (seq_done && seq_pass),
        .inc_i  (seq_done && !seq_pass),
        .last_o (fail_last)
    );

    // Main control: entry, programming and lockout.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_ENTRY;
            pos_q   <= '0;
            match_q <= 1'b1;
            ok_q    <= 1'b0;
            bad_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_ENTRY: begin
                    if (prog_take) begin
                        state_q <= ST_PROG;
                        ok_q    <= 1'b0;
                    end else if (press) begin
                        if (pos_q == '0) begin
                            ok_q  <= 1'b0;
                            bad_q <= 1'b0;
                        end
                        if (at_last) begin
                            pos_q   <= '0;
                            match_q <= 1'b1;
                            if (seq_pass) begin
                                ok_q <= 1'b1;
                            end else begin
                                bad_q <= 1'b1;
                                if (fail_last) state_q <= ST_LOCKOUT;
                            end
                        end else begin
                            pos_q   <= pos_q + 1'b1;
                            match_q <= match_q && digit_eq;
                        end
                    end
                end
                ST_PROG: begin
                    if (press) begin
                        if (at_last) begin
                            pos_q   <= '0;
                            state_q <= ST_ENTRY;
                        end else begin
                            pos_q <= pos_q + 1'b1;
                        end
                    end
                end
                ST_LOCKOUT: begin
                    state_q <= ST_LOCKOUT;
                end
                default: state_q <= ST_ENTRY;
            endcase
        end
    end

    assign ok_o      = ok_q;
    assign bad_o     = bad_q;
    assign lockout_o = (state_q == ST_LOCKOUT);
    assign pos_o     = pos_q;
endmodule

// File: rtl/combo_lock_checker.sv
// Property checker for combo_lock. Bound to every instance.
// Uses only the top-level ports and its own history registers.
module combo_lock_checker #(
    parameter int NUM_DIGITS = 4
) (
    input logic                          clk_i,
    input logic                          rst_ni,
    input logic                          enter_i,
    input logic                          ok_o,
    input logic                          bad_o,
    input logic                          lockout_o,
    input logic [$clog2(NUM_DIGITS)-1:0] pos_o
);
    localparam int POS_W = $clog2(NUM_DIGITS);

    logic armed_q;
    logic enter_d;
    logic rise_d;

    // Track history since reset, and whether the last edge saw an enter rise.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            armed_q <= 1'b0;
            enter_d <= 1'b0;
            rise_d  <= 1'b0;
        end else begin
            armed_q <= 1'b1;
            enter_d <= enter_i;
            rise_d  <= enter_i && !enter_d;
        end
    end

    assert_ok_bad_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ok_o && bad_o));

    assert_no_partial_result_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pos_o != '0) |-> (!ok_o && !bad_o));

    assert_lockout_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lockout_o |=> (lockout_o && bad_o && !ok_o && (pos_o == '0)));

    assert_lockout_with_bad_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lockout_o |-> bad_o);

    assert_pos_moves_on_press_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && (pos_o != $past(pos_o))) |-> rise_d);

    assert_pass_after_last_digit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && $rose(ok_o)) |-> ((pos_o == '0) && ($past(pos_o) == POS_W'(NUM_DIGITS - 1))));
endmodule

bind combo_lock combo_lock_checker #(.NUM_DIGITS(NUM_DIGITS)) u_checker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enter_i   (enter_i),
    .ok_o      (ok_o),
    .bad_o     (bad_o),
    .lockout_o (lockout_o),
    .pos_o     (pos_o)
);

// File: tb/combo_lock_test.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases, then seeded random sequences,
// all checked against a behavioural model of the requirements.
module combo_lock_test;
    localparam int ND = 4;
    localparam logic [15:0] DEF = 16'h1234;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] digit = '0;
    logic       enter = 1'b0;
    logic       prog = 1'b0;
    logic       ok, bad, lk;
    logic [1:0] pos;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;

    // Model state.
    logic [3:0] m_code [ND];
    int  m_pos, m_fails;
    bit  m_ok, m_bad, m_lk, m_prog, m_acc;

    always #2 clk = ~clk;

    combo_lock #(.DEFAULT_CODE(DEF)) uut (
        .clk_i(clk), .rst_ni(rst_n), .digit_i(digit), .enter_i(enter),
        .prog_req_i(prog), .ok_o(ok), .bad_o(bad), .lockout_o(lk), .pos_o(pos)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < ND; i++) m_code[i] = DEF[i*4 +: 4];
        m_pos = 0; m_fails = 0; m_ok = 0; m_bad = 0; m_lk = 0; m_prog = 0; m_acc = 1;
    endfunction

    function automatic void model_press(input logic [3:0] d);
        if (m_lk) return;
        if (m_prog) begin
            m_code[m_pos] = d;
            m_pos++;
            if (m_pos == ND) begin m_pos = 0; m_prog = 0; end
            return;
        end
        if (m_pos == 0) begin m_ok = 0; m_bad = 0; m_acc = 1; end
        m_acc = m_acc && (d == m_code[m_pos]);
        m_pos++;
        if (m_pos == ND) begin
            m_pos = 0;
            if (m_acc) begin m_ok = 1; m_fails = 0; end
            else begin
                m_bad = 1; m_fails++;
                if (m_fails >= 3) m_lk = 1;
            end
        end
    endfunction

    function automatic bit model_prog();
        if (!m_lk && !m_prog && m_ok && m_pos == 0) begin
            m_prog = 1; m_ok = 0; return 1;
        end
        return 0;
    endfunction

    task automatic compare_all();
        chk("R3 pos_o", int'(pos), m_pos);
        chk("R4 ok_o", int'(ok), int'(m_ok));
        chk("R5 bad_o", int'(bad), int'(m_bad));
        chk("R7 lockout_o", int'(lk), int'(m_lk));
    endtask

    task automatic press(input logic [3:0] d);
        @(negedge clk); digit = d; enter = 1'b1; model_press(d);
        @(negedge clk); enter = 1'b0;
        compare_all();
        @(negedge clk);
    endtask

    task automatic enter_seq(input logic [3:0] a, b, c, e);
        press(a); press(b); press(c); press(e);
    endtask

    task automatic enter_code();
        logic [3:0] cd [ND];
        for (int i = 0; i < ND; i++) cd[i] = m_code[i];
        for (int i = 0; i < ND; i++) press(cd[i]);
    endtask

    task automatic request();
        @(negedge clk); prog = 1'b1; void'(model_prog());
        @(negedge clk); prog = 1'b0;
        compare_all();
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 ok_o reset", int'(ok), 0);
        chk("R1 bad_o reset", int'(bad), 0);
        chk("R1 lockout_o reset", int'(lk), 0);
        chk("R1 pos_o reset", int'(pos), 0);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R3 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        model_reset();
        do_reset();

        // R1/R4: the default code passes.
        enter_code();
        chk("R4 default code passes", int'(ok), 1);
        // R6: the result holds while idle.
        repeat (6) @(negedge clk);
        chk("R6 ok_o held", int'(ok), 1);
        press(m_code[0]);
        chk("R6 ok_o cleared by first digit", int'(ok), 0);

        // R2: held enter takes one digit.
        @(negedge clk); digit = m_code[1]; enter = 1'b1; model_press(m_code[1]);
        repeat (6) @(negedge clk);
        chk("R2 held enter single capture", int'(pos), 2);
        enter = 1'b0;
        press(m_code[2]); press(m_code[3]);
        chk("R4 pass after held press", int'(ok), 1);

        // R8: a success clears the failure count.
        enter_seq(4'h9, 4'h9, 4'h9, 4'h9);
        enter_seq(4'h4, 4'h3, 4'h2, 4'h0);
        chk("R5 last digit wrong", int'(bad), 1);
        enter_code();
        enter_seq(4'h0, 4'h3, 4'h2, 4'h1);
        enter_seq(4'h4, 4'h3, 4'h7, 4'h1);
        chk("R8 no lockout after success", int'(lk), 0);

        // R9: request ignored while ok_o is 0.
        request();
        enter_code();
        chk("R9 request ignored without pass", int'(ok), 1);

        // R9: a press in the same cycle as an accepted request is dropped.
        @(negedge clk); prog = 1'b1; enter = 1'b1; digit = 4'h7; void'(model_prog());
        @(negedge clk); prog = 1'b0; enter = 1'b0;
        chk("R9 press dropped with request", int'(pos), 0);
        chk("R9 ok_o cleared on accept", int'(ok), 0);
        @(negedge clk);

        // R10/R11: program 5,6,7,8.
        press(4'h5); press(4'h6); press(4'h7);
        chk("R11 no result while programming", int'(ok | bad), 0);
        press(4'h8);
        chk("R11 no result after programming", int'(ok | bad), 0);
        enter_seq(4'h4, 4'h3, 4'h2, 4'h1);
        chk("R10 old code fails", int'(bad), 1);
        enter_seq(4'h5, 4'h6, 4'h7, 4'h8);
        chk("R10 new code passes", int'(ok), 1);

        // R7: three failures in a row lock the block.
        enter_seq(4'h1, 4'h1, 4'h1, 4'h1);
        enter_seq(4'h1, 4'h1, 4'h1, 4'h1);
        chk("R7 not yet locked", int'(lk), 0);
        enter_seq(4'h1, 4'h1, 4'h1, 4'h1);
        chk("R7 locked", int'(lk), 1);
        enter_seq(4'h5, 4'h6, 4'h7, 4'h8);
        chk("R7 correct code ignored", int'(ok), 0);
        chk("R7 pos held", int'(pos), 0);
        request();
        chk("R7 still locked", int'(lk), 1);

        do_reset();
        enter_seq(4'h4, 4'h3, 4'h2, 4'h1);
        chk("R1 default code restored", int'(ok), 1);

        // Random phase.
        for (int it = 0; it < 300; it++) begin
            int r;
            r = int'($urandom % 8);
            case (r)
                0, 1, 2: enter_code();
                3: begin
                    logic [3:0] cd [ND];
                    int idx;
                    idx = int'($urandom % ND);
                    for (int i = 0; i < ND; i++) cd[i] = m_code[i];
                    cd[idx] = cd[idx] ^ 4'(1 + $urandom % 15);
                    for (int i = 0; i < ND; i++) press(cd[i]);
                end
                4, 5: for (int i = 0; i < ND; i++) press(4'($urandom));
                6: begin
                    request();
                    if (m_prog) for (int i = 0; i < ND; i++) press(4'($urandom % 4));
                end
                default: begin
                    if (m_lk) do_reset();
                    else request();
                end
            endcase
            repeat (int'($urandom % 3)) @(negedge clk);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule